// File: doc/BRIEF.md
# Compare and Branch Resolution Unit

This unit sits in the execute stage of a 32-bit processor and handles two kinds of instruction. A compare instruction presents two operands; the unit judges them as signed two's-complement numbers and records the outcome in a five-bit status register. A jump instruction presents its opcode, a base-register value and a 16-bit offset. The unit forms the target as base plus sign-extended offset and decides, from the flags recorded by the most recent compare, whether the jump goes.

Results are registered. An instruction issued in one cycle has its verdict (taken, target, or a misaligned-target fault) on the outputs in the following cycle, for that cycle only. A compare immediately followed by a jump is resolved against the new flags. A zero base value gives absolute addressing. Fetch redirection, flushing and writeback belong to neighbouring logic.

The resolver is a four-state machine. States: `ST_IDLE` (no verdict), `ST_TAKE` (taken with target), `ST_SKIP` (jump resolved not taken), `ST_FAULT` (jump would go but target is misaligned). Transitions are taken every clock from whatever the current state is: an issued jump whose condition fails goes to `ST_SKIP`; one whose condition holds goes to `ST_TAKE` when the target's two low bits are zero and to `ST_FAULT` otherwise; anything else (no issue, a compare, any other opcode) goes to `ST_IDLE`. Reset enters `ST_IDLE`.

Top module: `branch_resolve_unit`

## Requirements
- R1: After reset the status flags read 0, and `jump_taken` and `target_fault` are 0.
- R2: A compare (opcode 0x0C) with `issue_valid` high loads the flags in the next cycle as signed relations of `src_a` against `src_b`: bit 0 equal, bit 1 greater, bit 2 less, bit 3 greater-or-equal, bit 4 less-or-equal.
- R3: The flags change only on an issued compare; jumps, other opcodes and idle cycles leave them unchanged.
- R4: For a taken or faulting jump, `jump_target` in the result cycle equals `src_a` plus `offset` sign-extended from 16 bits, as issued.
- R5: Opcode 0x0D jumps unconditionally, whatever the flags hold.
- R6: Conditional opcodes: 0x0E goes when equal is set, 0x0F when equal is clear, 0x10 when greater is set, 0x11 when greater or equal is set, 0x12 when less is set, 0x13 when less or equal is set.
- R7: `jump_taken` is high only in the cycle after an issued jump opcode (0x0D to 0x13); a compare, any other opcode, or a jump presented with `issue_valid` low never raises it.
- R8: A jump whose condition holds but whose target has either of its two low bits set raises `target_fault` for one cycle and leaves `jump_taken` low; `jump_taken` and `target_fault` are never high together.
- R9: A jump whose condition fails raises neither output, even with a misaligned target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 6 | Instruction opcode |
| src_a | input | 32 | First compare operand, or jump base value |
| src_b | input | 32 | Second compare operand |
| offset | input | 16 | Jump offset, signed |
| jump_taken | output | 1 | Jump goes this cycle |
| jump_target | output | 32 | Computed jump target |
| target_fault | output | 1 | Misaligned target instead of a taken jump |
| status_flags | output | 5 | Latched compare flags |

## Verification
A corrupted status register shows up at `status_flags` one cycle after the compare that set it, and again in the verdict of the next conditional jump, so the bench compares the flags against its own model on every clock rather than only around jumps. A wrong resolver state shows up in the single result cycle as a missing, extra or misclassified pulse on `jump_taken` or `target_fault`; since each verdict lasts exactly one cycle, the per-clock comparison catches a stuck or doubled pulse in the very cycle it occurs. Boundary operands (most negative against most positive, equal values, negative offsets) separate signed from unsigned judgement.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int OP_W = 6;
    localparam int FLAG_W = 5;

    localparam logic [OP_W-1:0] OP_CMP = 6'h0C;
    localparam logic [OP_W-1:0] OP_JMP = 6'h0D;
    localparam logic [OP_W-1:0] OP_JEQ = 6'h0E;
    localparam logic [OP_W-1:0] OP_JNE = 6'h0F;
    localparam logic [OP_W-1:0] OP_JGT = 6'h10;
    localparam logic [OP_W-1:0] OP_JGE = 6'h11;
    localparam logic [OP_W-1:0] OP_JLT = 6'h12;
    localparam logic [OP_W-1:0] OP_JLE = 6'h13;

    localparam int F_EQ = 0;
    localparam int F_GT = 1;
    localparam int F_LT = 2;
    localparam int F_GE = 3;
    localparam int F_LE = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TAKE  = 2'd1,
        ST_SKIP  = 2'd2,
        ST_FAULT = 2'd3
    } res_state_t;

    function automatic logic op_is_jump(input logic [OP_W-1:0] op);
        return (op >= OP_JMP) && (op <= OP_JLE);
    endfunction

endpackage

// File: rtl/bru_relate.sv
module bru_relate
    import bru_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [FLAG_W-1:0] rel
);
    logic is_eq;
    logic is_gt;
    logic is_lt;

    always_comb begin
        is_eq = (lhs == rhs);
        is_lt = ($signed(lhs) < $signed(rhs));
        is_gt = !is_eq && !is_lt;
        rel          = '0;
        rel[F_EQ]    = is_eq;
        rel[F_GT]    = is_gt;
        rel[F_LT]    = is_lt;
        rel[F_GE]    = is_gt | is_eq;
        rel[F_LE]    = is_lt | is_eq;
    end
endmodule

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [FLAG_W-1:0] flags,
    output logic              is_jump,
    output logic              cond_ok
);
    always_comb begin
        is_jump = 1'b1;
        cond_ok = 1'b0;
        unique case (op)
            OP_JMP:  cond_ok = 1'b1;
            OP_JEQ:  cond_ok = flags[F_EQ];
            OP_JNE:  cond_ok = !flags[F_EQ];
            OP_JGT:  cond_ok = flags[F_GT];
            OP_JGE:  cond_ok = flags[F_GT] | flags[F_EQ];
            OP_JLT:  cond_ok = flags[F_LT];
            OP_JLE:  cond_ok = flags[F_LT] | flags[F_EQ];
            default: is_jump = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_target_gen.sv
module bru_target_gen #(
    parameter int DATA_W     = 32,
    parameter int OFF_W      = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic [DATA_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] tgt,
    output logic              aligned
);
    localparam int EXT_W = DATA_W - OFF_W;

    logic [DATA_W-1:0] off_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        end else begin : g_trunc
            assign off_ext = off[DATA_W-1:0];
        end
    endgenerate

    assign tgt     = base + off_ext;
    assign aligned = (tgt[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import bru_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int OFF_W      = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [5:0]        opcode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [OFF_W-1:0]  offset,
    output logic              jump_taken,
    output logic [DATA_W-1:0] jump_target,
    output logic              target_fault,
    output logic [4:0]        status_flags
);
    logic [FLAG_W-1:0] rel_now;
    logic [FLAG_W-1:0] flag_q;
    logic              dec_jump;
    logic              dec_cond;
    logic [DATA_W-1:0] tgt_now;
    logic              tgt_aligned;
    logic [DATA_W-1:0] tgt_q;
    res_state_t        state_q;
    res_state_t        state_d;

    bru_relate #(.DATA_W(DATA_W)) u_relate (
        .lhs (src_a),
        .rhs (src_b),
        .rel (rel_now)
    );

    bru_cond_eval u_cond (
        .op      (opcode),
        .flags   (flag_q),
        .is_jump (dec_jump),
        .cond_ok (dec_cond)
    );

    bru_target_gen #(
        .DATA_W     (DATA_W),
        .OFF_W      (OFF_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_target (
        .base    (src_a),
        .off     (offset),
        .tgt     (tgt_now),
        .aligned (tgt_aligned)
    );

    // Status register: only an issued compare writes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (issue_valid && opcode == OP_CMP) begin
            flag_q <= rel_now;
        end
    end

    // Target register: captured for every issued jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (issue_valid && dec_jump) begin
            tgt_q <= tgt_now;
        end
    end

    // Next-state selection.
    always_comb begin
        state_d = ST_IDLE;
        if (issue_valid && dec_jump) begin
            if (!dec_cond) begin
                state_d = ST_SKIP;
            end else if (tgt_aligned) begin
                state_d = ST_TAKE;
            end else begin
                state_d = ST_FAULT;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode from state.
    always_comb begin
        jump_taken   = 1'b0;
        target_fault = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SKIP:  ;
            ST_TAKE:  jump_taken   = 1'b1;
            ST_FAULT: target_fault = 1'b1;
            default:  ;
        endcase
    end

    assign jump_target  = tgt_q;
    assign status_flags = flag_q;

endmodule

// File: rtl/bru_checker.sv
module bru_checker
    import bru_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic [5:0]        opcode,
    input logic [DATA_W-1:0] src_a,
    input logic [OFF_W-1:0]  offset,
    input logic              jump_taken,
    input logic [DATA_W-1:0] jump_target,
    input logic              target_fault,
    input logic [4:0]        status_flags
);
    logic seen_clk;
    always_ff @(posedge clk) seen_clk <= 1'b1;

    // R1: cleared outputs right after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (status_flags == '0 && !jump_taken && !target_fault));

    // R2: exactly one of equal/greater/less once any flag is set
    a_r2_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
        (status_flags != '0) |-> ($countones(status_flags[2:0]) == 1));

    // R3: flags hold when no compare is issued
    a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_clk && rst_n && !(issue_valid && opcode == OP_CMP)) |=> $stable(status_flags));

    // R4: target is base plus sign-extended offset
    a_r4_target_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op_is_jump(opcode)) |=>
            (jump_target == $past(src_a) + {{(DATA_W-OFF_W){$past(offset[OFF_W-1])}}, $past(offset)}));

    // R7: taken only after an issued jump
    a_r7_taken_needs_jump: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && op_is_jump(opcode)) |=> (!jump_taken && !target_fault));

    // R8: never both, and a taken target is aligned
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(jump_taken && target_fault));
    a_r8_taken_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        jump_taken |-> (jump_target[1:0] == 2'b00));
    a_r8_fault_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        target_fault |-> (jump_target[1:0] != 2'b00));

endmodule

bind branch_resolve_unit bru_checker #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_valid  (issue_valid),
    .opcode       (opcode),
    .src_a        (src_a),
    .offset       (offset),
    .jump_taken   (jump_taken),
    .jump_target  (jump_target),
    .target_fault (target_fault),
    .status_flags (status_flags)
);

// File: tb/branch_resolve_unit_test.sv
module branch_resolve_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] offset = '0;
    logic        jump_taken;
    logic [31:0] jump_target;
    logic        target_fault;
    logic [4:0]  status_flags;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // reference state
    logic [4:0] m_flags = '0;

    always #5 clk = ~clk;

    branch_resolve_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid  (issue_valid),
        .opcode       (opcode),
        .src_a        (src_a),
        .src_b        (src_b),
        .offset       (offset),
        .jump_taken   (jump_taken),
        .jump_target  (jump_target),
        .target_fault (target_fault),
        .status_flags (status_flags)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One instruction per clock; outputs checked at the following negedge.
    task automatic step(input string tag, input bit v, input logic [5:0] op,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] off);
        logic [31:0] tgt;
        bit          jmp;
        bit          go;
        bit          e_take;
        bit          e_fault;
        logic [4:0]  nf;
        jmp = v && (op >= 6'h0D) && (op <= 6'h13);
        tgt = a + {{16{off[15]}}, off};
        case (op)
            6'h0D: go = 1;
            6'h0E: go = m_flags[0];
            6'h0F: go = !m_flags[0];
            6'h10: go = m_flags[1];
            6'h11: go = m_flags[1] || m_flags[0];
            6'h12: go = m_flags[2];
            6'h13: go = m_flags[2] || m_flags[0];
            default: go = 0;
        endcase
        e_take  = jmp && go && (tgt[1:0] == 2'b00);
        e_fault = jmp && go && (tgt[1:0] != 2'b00);
        nf = m_flags;
        if (v && op == 6'h0C) begin
            nf[0] = (a == b);
            nf[1] = ($signed(a) > $signed(b));
            nf[2] = ($signed(a) < $signed(b));
            nf[3] = ($signed(a) >= $signed(b));
            nf[4] = ($signed(a) <= $signed(b));
        end
        issue_valid = v;
        opcode = op;
        src_a = a;
        src_b = b;
        offset = off;
        @(posedge clk);
        m_flags = nf;
        @(negedge clk);
        issue_valid = 1'b0;
        check(tag, "jump_taken", {31'b0, jump_taken}, {31'b0, e_take});
        check(tag, "target_fault", {31'b0, target_fault}, {31'b0, e_fault});
        check(tag, "status_flags", {27'b0, status_flags}, {27'b0, m_flags});
        if (e_take || e_fault)
            check("R4", "jump_target", jump_target, tgt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "flags after reset", {27'b0, status_flags}, 32'h0);
        check("R1", "taken after reset", {31'b0, jump_taken}, 32'h0);
        check("R1", "fault after reset", {31'b0, target_fault}, 32'h0);
        rst_n = 1'b1;

        // R5: unconditional, flags clear, absolute and register-relative
        step("R5", 1, 6'h0D, 32'h0, 0, 16'h4000);
        step("R5", 1, 6'h0D, 32'h0000_1000, 0, 16'hFFFC);
        // R6 with flags clear: ne goes, others stay
        step("R6", 1, 6'h0F, 32'h100, 0, 16'h0008);
        step("R6", 1, 6'h0E, 32'h100, 0, 16'h0008);
        step("R6", 1, 6'h11, 32'h100, 0, 16'h0008);

        // R2: signed greater: 5 vs -3
        step("R2", 1, 6'h0C, 32'd5, 32'hFFFF_FFFD, 0);
        step("R6", 1, 6'h10, 32'h2000, 0, 16'h0010);
        step("R6", 1, 6'h11, 32'h2000, 0, 16'h0020);
        step("R6", 1, 6'h12, 32'h2000, 0, 16'h0030);
        step("R6", 1, 6'h13, 32'h2000, 0, 16'h0030);
        step("R6", 1, 6'h0E, 32'h2000, 0, 16'h0030);
        // R3: idle, non-jump opcode and jumps keep flags
        step("R3", 0, 6'h0C, 32'd1, 32'd1, 0);
        step("R3", 1, 6'h05, 32'd1, 32'd1, 0);
        step("R7", 0, 6'h0D, 32'h40, 0, 0);
        step("R7", 1, 6'h00, 32'h40, 0, 0);
        step("R7", 1, 6'h14, 32'h40, 0, 0);

        // R2: most negative vs most positive gives less
        step("R2", 1, 6'h0C, 32'h8000_0000, 32'h7FFF_FFFF, 0);
        step("R6", 1, 6'h12, 32'h3000, 0, 16'hFFF0);
        step("R6", 1, 6'h13, 32'h3000, 0, 16'h0004);
        step("R6", 1, 6'h10, 32'h3000, 0, 16'h0004);
        step("R6", 1, 6'h0F, 32'h3000, 0, 16'h0004);

        // R2: equal
        step("R2", 1, 6'h0C, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0);
        step("R6", 1, 6'h0E, 32'h0, 0, 16'h0100);
        step("R6", 1, 6'h11, 32'h0, 0, 16'h0104);
        step("R6", 1, 6'h13, 32'h0, 0, 16'h0108);
        step("R6", 1, 6'h0F, 32'h0, 0, 16'h0108);
        // back-to-back compare then jump uses new flags
        step("R2", 1, 6'h0C, 32'd2, 32'd9, 0);
        step("R6", 1, 6'h12, 32'h500, 0, 16'h0000);
        // consecutive taken jumps
        step("R7", 1, 6'h0D, 32'h600, 0, 16'h0004);
        step("R7", 1, 6'h0D, 32'h700, 0, 16'h0008);

        // R8: misaligned taken target faults
        step("R8", 1, 6'h0D, 32'h1000, 0, 16'h0002);
        step("R8", 1, 6'h12, 32'h1001, 0, 16'h0000);
        step("R8", 1, 6'h0D, 32'h0000_0003, 0, 16'hFFFF);
        // R9: failing condition with misaligned target stays quiet
        step("R9", 1, 6'h10, 32'h1001, 0, 16'h0000);
        step("R9", 1, 6'h0E, 32'h1002, 0, 16'h0001);
        step("R3", 0, 6'h00, 0, 0, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule